// File: doc/BRIEF.md
# Atomic Fetch-and-Add Sequencer

This block runs one atomic fetch-and-add against a single-port memory on behalf of a simple load/store core. On a start pulse it captures a base value, a signed 16-bit offset, an increment and the current program counter. It forms the target address, reads the stored word, adds the increment, writes the sum back, and hands the value it read to the destination register. It then steps the program counter past the instruction.

A lock output keeps every other bus master away from memory from the first read cycle until the write is accepted, so nothing can reach the location between the read and the write. A fault input is sampled in the addition state, which comes before any memory word or register has been changed. A fault there abandons the operation with no write and no register update, and the same instruction can simply be issued again.

The sequence has five states after idle: address, read, add, write and program-counter step. The read and the write each wait for memory ready.

Top module: `fadd_seq`

## Requirements
- R1: After reset the block is idle. busy_o, mem_rd_o, mem_wr_o, mem_lock_o, rd_we_o, pc_we_o, done_o and abort_o are all low.
- R2: The target address is base plus the offset sign-extended from 16 bits. The first cycle after start is an address-forming cycle with busy_o high and mem_rd_o low. mem_addr_o carries the target address during the read and the write.
- R3: mem_rd_o stays high with a stable address until a cycle in which mem_rdy_i is high. The read data is captured in that cycle.
- R4: The write presents old value + increment on mem_wdata_o and holds mem_wr_o with stable data until mem_rdy_i is high.
- R5: rd_we_o pulses in the cycle the write is accepted, with rd_data_o equal to the value read before the addition.
- R6: mem_lock_o is high without a gap from the first read cycle through the cycle the write is accepted, and low in every other cycle.
- R7: If fault_i is high in the add state, abort_o pulses in that cycle. No write, no rd_we_o and no pc_we_o follow, the lock drops the next cycle and the block returns to idle. Memory is left unchanged, so a reissued operation sees the same old value.
- R8: fault_i in any state other than the add state has no effect.
- R9: The cycle after the write is accepted, done_o and pc_we_o pulse together with pc_o equal to the captured program counter + 4.
- R10: start and the operand inputs are ignored while busy_o is high.
- R11: Address, sum and program counter arithmetic wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| base_i | input | 32 | Base register value |
| imm_i | input | 16 | Signed address offset |
| incr_i | input | 32 | Increment operand |
| pc_i | input | 32 | Program counter of the instruction |
| fault_i | input | 1 | Page fault indication, sampled in the add state |
| mem_rdata_i | input | 32 | Memory read data |
| mem_rdy_i | input | 1 | Memory ready, accepts the current read or write |
| mem_addr_o | output | 32 | Memory address |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_wdata_o | output | 32 | Memory write data |
| mem_lock_o | output | 1 | Bus lock held across the read-modify-write |
| rd_we_o | output | 1 | Destination register write enable |
| rd_data_o | output | 32 | Old memory value for the destination register |
| pc_we_o | output | 1 | Program counter write enable |
| pc_o | output | 32 | Next program counter |
| done_o | output | 1 | Operation completed |
| abort_o | output | 1 | Operation abandoned on a fault |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench holds memory ready low for random stretches. A design that samples read data or drops the request early then returns the wrong old value or writes the wrong sum. The lock is compared against the read-to-write window in every cycle, which exposes a lock that is released during the add state or that arrives late. Fault pulses are aimed at the add state and also scattered over the other states. A faulted operation is then reissued at the same address: a design that wrote before aborting would return a changed old value, and a design that reacts to faults outside the add state would abort by mistake. Operands that wrap the address and the sum, and start pulses sent with junk operands during a busy sequence, catch missing wraparound and input recapture.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EA,
        ST_RD,
        ST_SUM,
        ST_WR,
        ST_PC
    } fadd_st_e;
endpackage

// File: rtl/fadd_agen.sv
module fadd_agen #(
    parameter int DW    = 32,
    parameter int IMM_W = 16
) (
    input  logic [DW-1:0]    base,
    input  logic [IMM_W-1:0] ofs,
    output logic [DW-1:0]    ea
);
    localparam int EXT_W = DW - IMM_W;

    logic [DW-1:0] ofs_ext;

    // sign-extend the offset to the data width
    assign ofs_ext = {{EXT_W{ofs[IMM_W-1]}}, ofs};
    assign ea      = base + ofs_ext;
endmodule

// File: rtl/fadd_adder.sv
module fadd_adder #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    assign y = a + b;
endmodule

// File: rtl/fadd_seq.sv
module fadd_seq
    import fadd_pkg::*;
#(
    parameter int DW      = 32,
    parameter int IMM_W   = 16,
    parameter int PC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [DW-1:0]    incr_i,
    input  logic [DW-1:0]    pc_i,
    input  logic             fault_i,
    input  logic [DW-1:0]    mem_rdata_i,
    input  logic             mem_rdy_i,
    output logic [DW-1:0]    mem_addr_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [DW-1:0]    mem_wdata_o,
    output logic             mem_lock_o,
    output logic             rd_we_o,
    output logic [DW-1:0]    rd_data_o,
    output logic             pc_we_o,
    output logic [DW-1:0]    pc_o,
    output logic             done_o,
    output logic             abort_o,
    output logic             busy_o
);
    localparam logic [DW-1:0] STEP = DW'(PC_STEP);

    typedef struct packed {
        fadd_st_e         st;
        logic [DW-1:0]    base;
        logic [IMM_W-1:0] imm;
        logic [DW-1:0]    incr;
        logic [DW-1:0]    pc;
        logic [DW-1:0]    ea;
        logic [DW-1:0]    old;
        logic [DW-1:0]    sum;
    } fadd_regs_t;

    fadd_regs_t r_d, r_q;

    logic [DW-1:0] ea_w;
    logic [DW-1:0] sum_w;
    logic [DW-1:0] pc_next_w;

    fadd_agen #(.DW(DW), .IMM_W(IMM_W)) u_agen (
        .base (r_q.base),
        .ofs  (r_q.imm),
        .ea   (ea_w)
    );

    fadd_adder #(.DW(DW)) u_sum_add (
        .a (r_q.old),
        .b (r_q.incr),
        .y (sum_w)
    );

    fadd_adder #(.DW(DW)) u_pc_add (
        .a (r_q.pc),
        .b (STEP),
        .y (pc_next_w)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_EA;
                    r_d.base = base_i;
                    r_d.imm  = imm_i;
                    r_d.incr = incr_i;
                    r_d.pc   = pc_i;
                end
            end
            ST_EA: begin
                r_d.ea = ea_w;
                r_d.st = ST_RD;
            end
            ST_RD: begin
                if (mem_rdy_i) begin
                    r_d.old = mem_rdata_i;
                    r_d.st  = ST_SUM;
                end
            end
            ST_SUM: begin
                if (fault_i) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.sum = sum_w;
                    r_d.st  = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_rdy_i) begin
                    r_d.st = ST_PC;
                end
            end
            ST_PC: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, imm: '0, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign mem_addr_o  = r_q.ea;
    assign mem_rd_o    = (r_q.st == ST_RD);
    assign mem_wr_o    = (r_q.st == ST_WR);
    assign mem_wdata_o = r_q.sum;
    assign mem_lock_o  = (r_q.st == ST_RD) || (r_q.st == ST_SUM) || (r_q.st == ST_WR);
    assign rd_we_o     = (r_q.st == ST_WR) && mem_rdy_i;
    assign rd_data_o   = r_q.old;
    assign pc_we_o     = (r_q.st == ST_PC);
    assign pc_o        = pc_next_w;
    assign done_o      = (r_q.st == ST_PC);
    assign abort_o     = (r_q.st == ST_SUM) && fault_i;
endmodule

// File: rtl/fadd_seq_chk.sv
module fadd_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] mem_addr_o,
    input logic          mem_rd_o,
    input logic          mem_wr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_lock_o,
    input logic          mem_rdy_i,
    input logic          rd_we_o,
    input logic          pc_we_o,
    input logic          done_o,
    input logic          abort_o,
    input logic          busy_o
);
    // R6
    rd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> mem_lock_o);

    // R6
    wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> mem_lock_o);

    // R6
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock_o) |-> ($past(mem_wr_o && mem_rdy_i) || $past(abort_o)));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_rdy_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_rdy_i) |=> (mem_wr_o && $stable(mem_wdata_o)));

    // R5
    rd_we_when_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> (mem_wr_o && mem_rdy_i));

    // R7
    abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (!mem_wr_o && !mem_lock_o && !busy_o && !pc_we_o));

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_rdy_i) |=> (done_o && pc_we_o));

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o}));
endmodule

bind fadd_seq fadd_seq_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_lock_o  (mem_lock_o),
    .mem_rdy_i   (mem_rdy_i),
    .rd_we_o     (rd_we_o),
    .pc_we_o     (pc_we_o),
    .done_o      (done_o),
    .abort_o     (abort_o),
    .busy_o      (busy_o)
);

// File: tb/tb_fadd_seq.sv
`timescale 1ns/1ps
module tb_fadd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] incr_i = '0;
    logic [31:0] pc_i = '0;
    logic        fault_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_rdy_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, rd_data_o, pc_o;
    logic        mem_rd_o, mem_wr_o, mem_lock_o, rd_we_o, pc_we_o, done_o, abort_o, busy_o;

    int total = 0;
    int bad = 0;
    logic [31:0] mem [16];

    always #2.5 clk = ~clk;

    fadd_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_i(base_i), .imm_i(imm_i),
        .incr_i(incr_i), .pc_i(pc_i), .fault_i(fault_i), .mem_rdata_i(mem_rdata_i),
        .mem_rdy_i(mem_rdy_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
        .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_lock_o(mem_lock_o),
        .rd_we_o(rd_we_o), .rd_data_o(rd_data_o), .pc_we_o(pc_we_o), .pc_o(pc_o),
        .done_o(done_o), .abort_o(abort_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] im);
        return b + {{16{im[15]}}, im};
    endfunction

    task automatic run_op(input logic [31:0] b, input logic [15:0] im, input logic [31:0] inc,
                          input logic [31:0] p, input bit flt);
        logic [31:0] ea, old, sum;
        bit in_win, fin, wdone;
        ea  = ea_of(b, im);
        old = mem[ea[5:2]];
        sum = old + inc;
        in_win = 0; fin = 0; wdone = 0;
        @(negedge clk);
        base_i = b; imm_i = im; incr_i = inc; pc_i = p; start = 1'b1;
        @(negedge clk);
        // R10: junk operands and start while busy
        base_i = $urandom; imm_i = 16'($urandom); incr_i = $urandom; pc_i = $urandom;
        #1;
        chk(busy_o && !mem_rd_o && !mem_lock_o, "R2 address cycle", {busy_o, mem_rd_o, mem_lock_o}, 32'h4);
        for (int cyc = 0; cyc < 60 && !fin; cyc++) begin
            bit rdy, addph;
            @(negedge clk);
            start = 1'($urandom); base_i = $urandom; imm_i = 16'($urandom); incr_i = $urandom;
            rdy = ($urandom % 3) != 0;
            mem_rdy_i = rdy;
            mem_rdata_i = mem[ea[5:2]];
            addph = mem_lock_o && !mem_rd_o && !mem_wr_o;
            fault_i = addph ? flt : 1'($urandom);
            #1;
            if (mem_rd_o) in_win = 1;
            chk(mem_lock_o == in_win, "R6 lock window", 32'(mem_lock_o), 32'(in_win));
            if (mem_rd_o) chk(mem_addr_o == ea, "R2 read address", mem_addr_o, ea);
            if (addph && flt) begin
                chk(abort_o && !rd_we_o, "R7 abort pulse", 32'(abort_o), 32'h1);
                fin = 1; in_win = 0;
            end else begin
                chk(!abort_o, "R8 fault ignored", 32'(abort_o), 32'h0);
            end
            if (mem_wr_o) begin
                chk(mem_addr_o == ea, "R2 write address", mem_addr_o, ea);
                chk(mem_wdata_o == sum, "R4 write data", mem_wdata_o, sum);
                if (rdy) begin
                    chk(rd_we_o && rd_data_o == old, "R5 dest old value", rd_data_o, old);
                    mem[ea[5:2]] = mem_wdata_o;
                    wdone = 1; in_win = 0;
                end else begin
                    chk(!rd_we_o, "R5 no early rd_we", 32'(rd_we_o), 32'h0);
                end
            end
            if (done_o) begin
                chk(pc_we_o && pc_o == p + 32'd4 && wdone, "R9 pc step", pc_o, p + 32'd4);
                fin = 1;
            end
        end
        chk(fin, "R9 completion", 32'(fin), 32'h1);
        @(negedge clk);
        start = 1'b0; fault_i = 1'b0; mem_rdy_i = 1'b0;
        #1;
        chk(!busy_o && !mem_lock_o && !mem_wr_o && !done_o && !pc_we_o, "R7 back to idle",
            {busy_o, mem_lock_o, mem_wr_o, done_o}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd7411));
        for (int i = 0; i < 16; i++) mem[i] = 32'h0101_0101 * i;
        mem[0] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk(!busy_o && !mem_rd_o && !mem_wr_o && !mem_lock_o && !rd_we_o && !pc_we_o && !done_o && !abort_o,
            "R1 reset idle", {busy_o, mem_lock_o}, 32'h0);
        rst_n = 1'b1;
        // directed: plain op
        run_op(32'h0000_1000, 16'h0008, 32'd10, 32'h0000_0400, 1'b0);
        // R11: address and sum wrap (ea = 0, 0xFFFFFFFF + 5 = 4)
        run_op(32'hFFFF_FFF0, 16'h0010, 32'd5, 32'hFFFF_FFFC, 1'b0);
        chk(mem[0] == 32'd4, "R11 sum wrap", mem[0], 32'd4);
        // negative offset
        run_op(32'h0000_2020, 16'hFFF0, 32'd3, 32'h0000_0010, 1'b0);
        // R7: fault then reissue sees unchanged memory
        run_op(32'h0000_0030, 16'h0000, 32'd99, 32'h0000_0100, 1'b1);
        run_op(32'h0000_0030, 16'h0000, 32'd99, 32'h0000_0100, 1'b0);
        // random ops
        for (int n = 0; n < 40; n++)
            run_op($urandom, 16'($urandom), $urandom, $urandom & 32'hFFFF_FFFC, ($urandom % 4) == 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule